// File: doc/BRIEF.md
# TileLink Message Legality Monitor

This block sits on one channel of a TileLink link as a passive observer. On every beat in which the sender raises valid and the receiver raises ready, it decodes the 3-bit opcode and the 3-bit param field. It then decides whether that opcode may appear on the channel at all. If it may, it also checks whether the param value falls within the range that this opcode allows on this channel. The first illegal beat after reset sets a sticky error flag. It also records an error code, together with the opcode and param that caused it.

The channel under watch is picked by the parameter `CHAN` (0 = A, 1 = B, 2 = C, 3 = D). Channels A and B share one rule set. C and D each have their own rules. The monitor drives neither valid nor ready and never applies back-pressure. A beat counts only in a cycle where both are high. A beat held with valid high and ready low is observed only in the cycle where ready finally rises. Cycles where valid is low are ignored whatever the other fields carry.

Top module: `tl_msg_legality_mon`

## Requirements
- R1: A beat is examined only in a cycle where `mon_valid` and `mon_ready` are both 1; cycles with either low never set `err_flag`, whatever opcode and param carry.
- R2: Opcode legality: on channels A and B all eight opcodes 0..7 are legal; on channel C opcode 3 is illegal; on channel D opcodes 3 and 7 are illegal.
- R3: A reserved param must be 0. On A/B this covers opcodes 0, 1 (writes) and 4 (read). On C it covers 0, 1 and 2 (access acks, hint ack). On D it covers 0, 1, 2 and 6 (access acks, hint ack, release ack).
- R4: On A/B, opcode 2 (arithmetic) accepts param 0..4 and opcode 3 (logical) accepts param 0..3.
- R5: On A/B, opcode 5 (intent) accepts param 0, 1, 5, 6 or 7 only.
- R6: On A/B, opcodes 6 and 7 (acquire or probe) accept param 0..2. On D, opcodes 4 and 5 (grant) accept a cap param 0..2.
- R7: On C, opcodes 4..7 (probe acks and releases) accept a shrink or report param 0..5; 6 and 7 are illegal.
- R8: `err_flag` stays 1 from the cycle after the first illegal beat until reset.
- R9: `err_code` is 0 when no error has occurred, 1 for an illegal opcode and 2 for an illegal param. `err_code`, `err_opcode` and `err_param` keep the first violation and ignore later ones.
- R10: An illegal opcode is reported with code 1 whatever its param value.
- R11: After reset, `err_flag`, `err_code`, `err_opcode` and `err_param` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Observed valid of the channel |
| mon_ready | input | 1 | Observed ready of the channel |
| mon_opcode | input | 3 | Observed opcode field |
| mon_param | input | 3 | Observed param field |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 2 | 0 none, 1 illegal opcode, 2 illegal param |
| err_opcode | output | 3 | Opcode of the first violating beat |
| err_param | output | 3 | Param of the first violating beat |

## Verification
The assertions assume that reset is applied before the first handshake. They also assume that opcode and param are known values in any cycle where valid and ready are both high. The stimulus changes every input on the falling clock edge and holds known values at all times. It pulses reset before each isolated beat, so each beat is judged as the first after reset. All four channel variants see the same bus at once. This lets one opcode/param pair show the differing channel rules side by side. The sticky scenario sends several violations in a row and checks that only the first one is recorded.

// File: rtl/tlmc_pkg.sv
package tlmc_pkg;
  localparam int OP_W  = 3;
  localparam int PAR_W = 3;

  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CH_C = 2;
  localparam int CH_D = 3;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_OPCODE = 2'd1,
    ERR_PARAM  = 2'd2
  } err_e;

  // Which param range a decoded opcode expects
  typedef enum logic [2:0] {
    PK_ZERO,
    PK_ARITH,
    PK_LOGIC,
    PK_INTENT,
    PK_PERM3,
    PK_SHRINK6
  } pkind_e;
endpackage

// File: rtl/tlmc_op_decode.sv
module tlmc_op_decode
  import tlmc_pkg::*;
#(
  parameter int CHAN = CH_A
) (
  input  logic [OP_W-1:0] opcode,
  output logic            op_ok,
  output pkind_e          kind
);
  generate
    if (CHAN == CH_A || CHAN == CH_B) begin : g_req
      always_comb begin
        op_ok = 1'b1;
        unique case (opcode)
          3'd2:          kind = PK_ARITH;
          3'd3:          kind = PK_LOGIC;
          3'd5:          kind = PK_INTENT;
          3'd6, 3'd7:    kind = PK_PERM3;
          default:       kind = PK_ZERO;
        endcase
      end
    end else if (CHAN == CH_C) begin : g_rsp_c
      always_comb begin
        op_ok = (opcode != 3'd3);
        kind  = opcode[2] ? PK_SHRINK6 : PK_ZERO;
      end
    end else begin : g_rsp_d
      always_comb begin
        op_ok = (opcode != 3'd3) && (opcode != 3'd7);
        kind  = (opcode == 3'd4 || opcode == 3'd5) ? PK_PERM3 : PK_ZERO;
      end
    end
  endgenerate
endmodule

// File: rtl/tlmc_param_check.sv
module tlmc_param_check
  import tlmc_pkg::*;
(
  input  pkind_e           kind,
  input  logic [PAR_W-1:0] param,
  output logic             par_ok
);
  always_comb begin
    unique case (kind)
      PK_ZERO:    par_ok = (param == 3'd0);
      PK_ARITH:   par_ok = (param <= 3'd4);
      PK_LOGIC:   par_ok = (param <= 3'd3);
      PK_INTENT:  par_ok = (param <= 3'd1) || (param >= 3'd5);
      PK_PERM3:   par_ok = (param <= 3'd2);
      PK_SHRINK6: par_ok = (param <= 3'd5);
      default:    par_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlmc_err_capture.sv
module tlmc_err_capture
  import tlmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             op_ok,
  input  logic             par_ok,
  input  logic [OP_W-1:0]  opcode,
  input  logic [PAR_W-1:0] param,
  output logic             flag_q,
  output err_e             code_q,
  output logic [OP_W-1:0]  op_q,
  output logic [PAR_W-1:0] par_q
);
  logic bad;
  assign bad = fire && !flag_q && (!op_ok || !par_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= ERR_NONE;
      op_q   <= '0;
      par_q  <= '0;
    end else if (bad) begin
      flag_q <= 1'b1;
      code_q <= op_ok ? ERR_PARAM : ERR_OPCODE;
      op_q   <= opcode;
      par_q  <= param;
    end
  end
endmodule

// File: rtl/tl_msg_legality_mon.sv
module tl_msg_legality_mon
  import tlmc_pkg::*;
#(
  parameter int CHAN = CH_A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_valid,
  input  logic             mon_ready,
  input  logic [OP_W-1:0]  mon_opcode,
  input  logic [PAR_W-1:0] mon_param,
  output logic             err_flag,
  output logic [1:0]       err_code,
  output logic [OP_W-1:0]  err_opcode,
  output logic [PAR_W-1:0] err_param
);
  logic   op_ok;
  logic   par_ok;
  pkind_e kind;
  err_e   code_q;

  tlmc_op_decode #(.CHAN(CHAN)) dec_i (
    .opcode (mon_opcode),
    .op_ok  (op_ok),
    .kind   (kind)
  );

  tlmc_param_check par_i (
    .kind   (kind),
    .param  (mon_param),
    .par_ok (par_ok)
  );

  tlmc_err_capture cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (mon_valid && mon_ready),
    .op_ok  (op_ok),
    .par_ok (par_ok),
    .opcode (mon_opcode),
    .param  (mon_param),
    .flag_q (err_flag),
    .code_q (code_q),
    .op_q   (err_opcode),
    .par_q  (err_param)
  );

  assign err_code = code_q;
endmodule

// File: rtl/tl_msg_legality_mon_chk.sv
module tl_msg_legality_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mon_valid,
  input logic       mon_ready,
  input logic [2:0] mon_opcode,
  input logic [2:0] mon_param,
  input logic       err_flag,
  input logic [1:0] err_code,
  input logic [2:0] err_opcode,
  input logic [2:0] err_param
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mon_valid && mon_ready) && !err_flag) |=> !err_flag);

  // Param 6 is legal only for the intent opcode, on every channel variant
  p_param6_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && mon_ready && !err_flag && mon_param == 3'd6 && mon_opcode != 3'd5)
    |=> err_flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_first_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(err_code) && $stable(err_opcode) && $stable(err_param)));

  p_flag_code_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (err_code != 2'd0));

  p_capture_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && mon_ready && !err_flag) |=>
      (!err_flag || (err_opcode == $past(mon_opcode) && err_param == $past(mon_param))));
endmodule

bind tl_msg_legality_mon tl_msg_legality_mon_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_valid  (mon_valid),
  .mon_ready  (mon_ready),
  .mon_opcode (mon_opcode),
  .mon_param  (mon_param),
  .err_flag   (err_flag),
  .err_code   (err_code),
  .err_opcode (err_opcode),
  .err_param  (err_param)
);

// File: tb/tl_msg_legality_mon_tb_top.sv
`timescale 1ns/1ps
module tl_msg_legality_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, rdy = 1'b0;
  logic [2:0] opc = '0, prm = '0;

  logic       flg [4];
  logic [1:0] cod [4];
  logic [2:0] eop [4];
  logic [2:0] epr [4];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tl_msg_legality_mon #(.CHAN(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_valid(vld), .mon_ready(rdy),
    .mon_opcode(opc), .mon_param(prm),
    .err_flag(flg[0]), .err_code(cod[0]), .err_opcode(eop[0]), .err_param(epr[0]));
  tl_msg_legality_mon #(.CHAN(1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .mon_valid(vld), .mon_ready(rdy),
    .mon_opcode(opc), .mon_param(prm),
    .err_flag(flg[1]), .err_code(cod[1]), .err_opcode(eop[1]), .err_param(epr[1]));
  tl_msg_legality_mon #(.CHAN(2)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .mon_valid(vld), .mon_ready(rdy),
    .mon_opcode(opc), .mon_param(prm),
    .err_flag(flg[2]), .err_code(cod[2]), .err_opcode(eop[2]), .err_param(epr[2]));
  tl_msg_legality_mon #(.CHAN(3)) dut_d_i (
    .clk(clk), .rst_n(rst_n), .mon_valid(vld), .mon_ready(rdy),
    .mon_opcode(opc), .mon_param(prm),
    .err_flag(flg[3]), .err_code(cod[3]), .err_opcode(eop[3]), .err_param(epr[3]));

  // Expected verdict from the requirements: 0 legal, 1 bad opcode, 2 bad param
  function automatic int exp_code(int ch, int op, int pr);
    bit ok;
    if (ch <= 1) begin
      case (op)
        2:       ok = (pr <= 4);
        3:       ok = (pr <= 3);
        5:       ok = (pr == 0 || pr == 1 || pr == 5 || pr == 6 || pr == 7);
        6, 7:    ok = (pr <= 2);
        default: ok = (pr == 0);
      endcase
      return ok ? 0 : 2;
    end else if (ch == 2) begin
      if (op == 3) return 1;
      ok = (op >= 4) ? (pr <= 5) : (pr == 0);
      return ok ? 0 : 2;
    end else begin
      if (op == 3 || op == 7) return 1;
      ok = (op == 4 || op == 5) ? (pr <= 2) : (pr == 0);
      return ok ? 0 : 2;
    end
  endfunction

  task automatic check_ch(int ch, int ecode, int eo, int ep, string req);
    bit ok;
    n_chk++;
    ok = (cod[ch] == 2'(ecode)) && (flg[ch] == (ecode != 0));
    if (ecode != 0) ok = ok && (eop[ch] == 3'(eo)) && (epr[ch] == 3'(ep));
    else ok = ok && (eop[ch] == 3'd0) && (epr[ch] == 3'd0);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s ch%0d: got flag=%0d code=%0d op=%0d par=%0d, exp code=%0d op=%0d par=%0d",
               req, ch, flg[ch], cod[ch], eop[ch], epr[ch], ecode,
               (ecode != 0) ? eo : 0, (ecode != 0) ? ep : 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; rdy = 1'b0; opc = '0; prm = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One isolated handshake after reset; checks all four channel variants
  task automatic one_beat(int op, int pr, string req);
    do_reset();
    @(negedge clk);
    vld = 1'b1; rdy = 1'b1; opc = 3'(op); prm = 3'(pr);
    @(negedge clk);
    vld = 1'b0; rdy = 1'b0; opc = '0; prm = '0;
    for (int ch = 0; ch < 4; ch++) check_ch(ch, exp_code(ch, op, pr), op, pr, req);
  endtask

  task automatic t_reset_r11();
    do_reset();
    for (int ch = 0; ch < 4; ch++) check_ch(ch, 0, 0, 0, "R11");
  endtask

  task automatic t_opcode_set_r2();
    for (int op = 0; op < 8; op++) one_beat(op, 0, "R2");
  endtask

  task automatic t_opcode_priority_r10();
    one_beat(3, 7, "R10");
    one_beat(7, 6, "R10");
    one_beat(3, 5, "R10");
  endtask

  task automatic t_reserved_r3();
    int ops[5] = '{0, 1, 2, 4, 6};
    foreach (ops[i])
      for (int pr = 0; pr < 8; pr++) one_beat(ops[i], pr, "R3");
  endtask

  task automatic t_arith_logic_r4();
    for (int op = 2; op <= 3; op++)
      for (int pr = 0; pr < 8; pr++) one_beat(op, pr, "R4");
  endtask

  task automatic t_intent_r5();
    for (int pr = 0; pr < 8; pr++) one_beat(5, pr, "R5");
  endtask

  task automatic t_perm_r6_r7();
    for (int op = 4; op < 8; op++)
      for (int pr = 0; pr < 8; pr++) one_beat(op, pr, "R6 R7");
  endtask

  task automatic t_handshake_r1();
    do_reset();
    @(negedge clk);
    vld = 1'b1; rdy = 1'b0; opc = 3'd3; prm = 3'd7;
    repeat (3) @(negedge clk);
    vld = 1'b0; rdy = 1'b1;
    repeat (3) @(negedge clk);
    vld = 1'b0; rdy = 1'b0;
    @(negedge clk);
    for (int ch = 0; ch < 4; ch++) check_ch(ch, 0, 0, 0, "R1");
    // Held beat is taken once ready rises
    vld = 1'b1; rdy = 1'b1; opc = 3'd3; prm = 3'd7;
    @(negedge clk);
    vld = 1'b0; rdy = 1'b0;
    for (int ch = 0; ch < 4; ch++) check_ch(ch, exp_code(ch, 3, 7), 3, 7, "R1");
  endtask

  task automatic t_sticky_r8_r9();
    int seq_op[4] = '{3, 4, 0, 6};
    int seq_pr[4] = '{0, 1, 5, 7};
    int fc[4], fo[4], fp[4];
    for (int ch = 0; ch < 4; ch++) begin fc[ch] = 0; fo[ch] = 0; fp[ch] = 0; end
    do_reset();
    foreach (seq_op[i]) begin
      @(negedge clk);
      vld = 1'b1; rdy = 1'b1; opc = 3'(seq_op[i]); prm = 3'(seq_pr[i]);
      for (int ch = 0; ch < 4; ch++)
        if (fc[ch] == 0) begin
          fc[ch] = exp_code(ch, seq_op[i], seq_pr[i]);
          fo[ch] = seq_op[i]; fp[ch] = seq_pr[i];
        end
    end
    @(negedge clk);
    vld = 1'b0; rdy = 1'b0; opc = '0; prm = '0;
    repeat (5) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) check_ch(ch, fc[ch], fo[ch], fp[ch], "R8 R9");
    do_reset();
    for (int ch = 0; ch < 4; ch++) check_ch(ch, 0, 0, 0, "R8");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset_r11();
    t_handshake_r1();
    t_opcode_set_r2();
    t_opcode_priority_r10();
    t_reserved_r3();
    t_arith_logic_r4();
    t_intent_r5();
    t_perm_r6_r7();
    t_sticky_r8_r9();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule